// File: doc/BRIEF.md
# Cascadable Dual 16-bit Timer

This block holds two 16-bit up-counting timers, called A (lower) and B (upper), controlled from a small word-addressed register bus. Each timer takes the system clock or a divide-by-16 slow clock, passes it through its own 8-bit prescaler, and counts. It compares the next count against a reference value and sets a sticky event flag on a match. It can restart from zero on that match. It can also latch the live count on a rising edge of its capture input.

A shared control register releases each timer from reset, starts and stops it, and can join the pair into one 32-bit counter. In that joined form A carries into B, and the reference and restart act on the concatenated value. The 32-bit count and reference can then be written and read in one access at timer B's addresses. Each timer drives a registered interrupt request from its pending flags.

Register map (5-bit word address). Control at 0x00: bit0 run A, bit1 release A, bit2 run B, bit3 release B, bit4 join. Timer A sits at base 0x08 and timer B at base 0x10. The offsets are +0 mode, +1 count, +2 reference, +3 capture and +4 event. Mode bits are [7:0] divider N, [8] slow source, [9] restart, [10] reference interrupt enable and [11] capture enable. Event bits are bit0 reference and bit1 capture.

Top module: `dual_timer_pair`

## Requirements
- R1: After reset the control register reads 0, counts, modes, captures and event registers read 0, references read 0xFFFF, and both irq bits are 0.
- R2: A timer that is released (control release bit 1) and running (run bit 1) advances once per N+1 source ticks. The source is every clock (mode bit8 = 0) or every 16th clock (bit8 = 1). The prescaler phase restarts whenever the timer is stopped.
- R3: While its release bit is 0 a timer's count stays 0, writes to its count are ignored and its event flags are cleared.
- R4: When the value a step would load equals the reference, event bit0 is set. Without restart the count keeps incrementing and wraps from 0xFFFF to 0.
- R5: With mode bit9 set, the step that matches the reference loads 0 instead, so the period is reference steps.
- R6: With mode bit11 set, a rising edge on cap_in, after a two-flop synchronizer, latches the count into the capture register and sets event bit1. With bit11 clear the edge does nothing.
- R7: Writing the event register clears the bits written as 1 and leaves bits written as 0. A new event in the same cycle wins over the clear.
- R8: irq[i] is registered and equals (event bit0 AND mode bit10) OR event bit1.
- R9: With control bit4 set, {B,A} counts as one 32-bit value stepped by A's prescaler. A carries into B, the match compares against {refB,refA}, and A's restart bit and A's event bit0 apply.
- R10: With control bit4 set, a write to B's count or reference address loads bits [31:16] into B and [15:0] into A, and a read there returns {B,A}.
- R11: With control bit4 clear, B never changes because A wraps.
- R12: bus_rdata updates one cycle after bus_re and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cap_in | input | 2 | Asynchronous capture inputs, bit i for timer i |
| irq | output | 2 | Registered interrupt requests |

## Verification
Several properties are checked on every clock: a held timer reads zero on the next cycle, a restart match loads zero, and a separate upper half holds still when it does not step. The assertions also cover the carry into the upper half when joined, the sticky reference flag, the capture value against the count, the source of each irq rise, and prescaler tick spacing. Only the bench scenarios can show the exact step counts for each divider and source. They also show the full period under restart, the joined 32-bit access layout, the disabled capture path and the partial event clears, all by reading registers back after a run of known length.

// File: rtl/dtp_pkg.sv
package dtp_pkg;
  // register offsets within a timer window
  localparam logic [2:0] RG_MODE  = 3'd0;
  localparam logic [2:0] RG_COUNT = 3'd1;
  localparam logic [2:0] RG_REF   = 3'd2;
  localparam logic [2:0] RG_CAP   = 3'd3;
  localparam logic [2:0] RG_EVT   = 3'd4;
  // event bit positions
  localparam int EV_REF = 0;
  localparam int EV_CAP = 1;
  // control register bit positions
  localparam int GC_JOIN = 4;
  localparam int GC_W    = 5;
endpackage

// File: rtl/dtp_prescaler.sv
module dtp_prescaler #(
  parameter int PW       = 8,
  parameter int SLOW_DIV = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          slow,
  input  logic [PW-1:0] div,
  output logic          tick
);
  localparam int SW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [SW-1:0] SLOW_LAST = SW'(SLOW_DIV - 1);

  logic [SW-1:0] slow_cnt;
  logic [PW-1:0] pre_cnt;
  logic          src;

  always_comb src  = slow ? (slow_cnt == SLOW_LAST) : 1'b1;
  always_comb tick = active && src && (pre_cnt >= div);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      slow_cnt <= '0;
      pre_cnt  <= '0;
    end else begin
      slow_cnt <= (slow_cnt == SLOW_LAST) ? '0 : slow_cnt + 1'b1;
      if (src) pre_cnt <= (pre_cnt >= div) ? '0 : pre_cnt + 1'b1;
    end
  end

  // R2: with a divider above zero, two ticks are never adjacent
  a_r2_tick_gap: assert property (@(posedge clk) disable iff (rst)
    (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/dtp_edge_sync.sv
module dtp_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= din;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;

  // R6: a detected edge lasts exactly one cycle
  a_r6_one_pulse: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/dtp_count_pair.sv
module dtp_count_pair #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    clr,
  input  logic [1:0]    step,
  input  logic          hi_en,
  input  logic          join_mode,
  input  logic          restart_lo,
  input  logic          restart_hi,
  input  logic [CW-1:0] ref_lo,
  input  logic [CW-1:0] ref_hi,
  input  logic [1:0]    wr,
  input  logic [CW-1:0] wdat_lo,
  input  logic [CW-1:0] wdat_hi,
  output logic [CW-1:0] cnt_lo,
  output logic [CW-1:0] cnt_hi,
  output logic [1:0]    match
);
  localparam int DW = 2 * CW;

  logic [CW-1:0] inc_lo, inc_hi;
  logic [DW-1:0] joined_nx, joined_ref;
  logic          joined_hit;

  always_comb begin
    inc_lo     = cnt_lo + 1'b1;
    inc_hi     = cnt_hi + 1'b1;
    joined_nx  = {cnt_hi, cnt_lo} + 1'b1;
    joined_ref = {ref_hi, ref_lo};
    joined_hit = joined_nx == joined_ref;
    match[0]   = join_mode ? (step[0] && joined_hit)
                           : (step[0] && inc_lo == ref_lo);
    match[1]   = !join_mode && step[1] && (inc_hi == ref_hi);
  end

  always_ff @(posedge clk) begin
    if (rst || clr[0]) begin
      cnt_lo <= '0;
    end else if (wr[0]) begin
      cnt_lo <= wdat_lo;
    end else if (step[0]) begin
      cnt_lo <= (match[0] && restart_lo) ? '0 : inc_lo;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr[1]) begin
      cnt_hi <= '0;
    end else if (wr[1]) begin
      cnt_hi <= wdat_hi;
    end else if (join_mode) begin
      if (step[0] && hi_en)
        cnt_hi <= (match[0] && restart_lo) ? '0 : joined_nx[DW-1:CW];
    end else if (step[1]) begin
      cnt_hi <= (match[1] && restart_hi) ? '0 : inc_hi;
    end
  end

  // R3: a held timer reads zero on the following cycle
  a_r3_lo_held: assert property (@(posedge clk) disable iff (rst)
    clr[0] |=> cnt_lo == '0);
  a_r3_hi_held: assert property (@(posedge clk) disable iff (rst)
    clr[1] |=> cnt_hi == '0);
  // R5: a restart match loads zero
  a_r5_restart_zero: assert property (@(posedge clk) disable iff (rst)
    (match[0] && restart_lo && !clr[0] && !wr[0]) |=> cnt_lo == '0);
  // R11: separate upper half moves only on its own step or a write
  a_r11_hi_isolated: assert property (@(posedge clk) disable iff (rst)
    (!join_mode && !clr[1] && !wr[1] && !step[1]) |=> $stable(cnt_hi));
  // R9: a low wrap without match carries into the upper half
  a_r9_carry: assert property (@(posedge clk) disable iff (rst)
    (join_mode && step[0] && hi_en && cnt_lo == '1 && !match[0]
     && clr == 2'b00 && wr == 2'b00) |=> cnt_hi == $past(cnt_hi) + 1'b1);
endmodule

// File: rtl/dual_timer_pair.sv
module dual_timer_pair #(
  parameter int CW       = 16,
  parameter int PW       = 8,
  parameter int SLOW_DIV = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_we,
  input  logic            bus_re,
  input  logic [4:0]      bus_addr,
  input  logic [2*CW-1:0] bus_wdata,
  output logic [2*CW-1:0] bus_rdata,
  input  logic [1:0]      cap_in,
  output logic [1:0]      irq
);
  import dtp_pkg::*;

  localparam int DW      = 2 * CW;
  localparam int MW      = PW + 4;
  localparam int SLOW_B  = PW;
  localparam int RST_B   = PW + 1;
  localparam int IE_B    = PW + 2;
  localparam int CAPEN_B = PW + 3;

  logic [GC_W-1:0] gctl;
  logic [MW-1:0]   mode_q [2];
  logic [CW-1:0]   ref_q  [2];
  logic [CW-1:0]   cap_q  [2];
  logic [CW-1:0]   cnt_v  [2];
  logic [CW-1:0]   cnt_lo, cnt_hi;
  logic [1:0]      ev_ref, ev_cap;
  logic [1:0]      active, clr, tick, rise, fire, match;
  logic [1:0]      hit_t, wr_mode, wr_cnt, wr_ref, w1c;
  logic [1:0]      blk;
  logic [2:0]      sub;
  logic            hit_g, join_mode;
  logic [CW-1:0]   wdat_hi;
  logic [DW-1:0]   rd_mux;

  assign blk       = bus_addr[4:3];
  assign sub       = bus_addr[2:0];
  assign hit_g     = bus_addr == 5'd0;
  assign join_mode = gctl[GC_JOIN];
  assign cnt_v[0]  = cnt_lo;
  assign cnt_v[1]  = cnt_hi;
  assign wdat_hi   = join_mode ? bus_wdata[DW-1:CW] : bus_wdata[CW-1:0];

  always_comb begin
    active  = '0;
    clr     = '0;
    hit_t   = '0;
    wr_mode = '0;
    w1c     = '0;
    fire    = '0;
    for (int i = 0; i < 2; i++) begin
      active[i]  = gctl[2*i] & gctl[2*i+1];
      clr[i]     = ~gctl[2*i+1];
      hit_t[i]   = blk == 2'(i + 1);
      wr_mode[i] = bus_we & hit_t[i] & (sub == RG_MODE);
      w1c[i]     = bus_we & hit_t[i] & (sub == RG_EVT);
      fire[i]    = rise[i] & mode_q[i][CAPEN_B] & gctl[2*i+1];
    end
    // a joined access at the upper window also reaches the lower half
    wr_cnt[1] = bus_we & hit_t[1] & (sub == RG_COUNT);
    wr_ref[1] = bus_we & hit_t[1] & (sub == RG_REF);
    wr_cnt[0] = bus_we & (sub == RG_COUNT) & (hit_t[0] | (join_mode & hit_t[1]));
    wr_ref[0] = bus_we & (sub == RG_REF)   & (hit_t[0] | (join_mode & hit_t[1]));
  end

  for (genvar g = 0; g < 2; g++) begin : g_timer
    dtp_prescaler #(.PW(PW), .SLOW_DIV(SLOW_DIV)) u_pre (
      .clk    (clk),
      .rst    (rst),
      .active (active[g]),
      .slow   (mode_q[g][SLOW_B]),
      .div    (mode_q[g][PW-1:0]),
      .tick   (tick[g])
    );
    dtp_edge_sync u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (cap_in[g]),
      .rise (rise[g])
    );
  end

  dtp_count_pair #(.CW(CW)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr),
    .step       (tick),
    .hi_en      (active[1]),
    .join_mode  (join_mode),
    .restart_lo (mode_q[0][RST_B]),
    .restart_hi (mode_q[1][RST_B]),
    .ref_lo     (ref_q[0]),
    .ref_hi     (ref_q[1]),
    .wr         (wr_cnt),
    .wdat_lo    (bus_wdata[CW-1:0]),
    .wdat_hi    (wdat_hi),
    .cnt_lo     (cnt_lo),
    .cnt_hi     (cnt_hi),
    .match      (match)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gctl   <= '0;
      ev_ref <= '0;
      ev_cap <= '0;
      irq    <= '0;
      for (int i = 0; i < 2; i++) begin
        mode_q[i] <= '0;
        ref_q[i]  <= '1;
        cap_q[i]  <= '0;
      end
    end else begin
      if (bus_we && hit_g) gctl <= bus_wdata[GC_W-1:0];
      for (int i = 0; i < 2; i++) begin
        if (wr_mode[i]) mode_q[i] <= bus_wdata[MW-1:0];
        if (wr_ref[i])  ref_q[i]  <= (i == 1) ? wdat_hi : bus_wdata[CW-1:0];
        if (fire[i])    cap_q[i]  <= cnt_v[i];
        if (clr[i]) begin
          ev_ref[i] <= 1'b0;
          ev_cap[i] <= 1'b0;
        end else begin
          ev_ref[i] <= match[i] | (ev_ref[i] & ~(w1c[i] & bus_wdata[EV_REF]));
          ev_cap[i] <= fire[i]  | (ev_cap[i] & ~(w1c[i] & bus_wdata[EV_CAP]));
        end
        irq[i] <= (ev_ref[i] & mode_q[i][IE_B]) | ev_cap[i];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_g) rd_mux = DW'(gctl);
    for (int i = 0; i < 2; i++) begin
      if (hit_t[i]) begin
        case (sub)
          RG_MODE:  rd_mux = DW'(mode_q[i]);
          RG_COUNT: rd_mux = (i == 1 && join_mode) ? {cnt_hi, cnt_lo} : DW'(cnt_v[i]);
          RG_REF:   rd_mux = (i == 1 && join_mode) ? {ref_q[1], ref_q[0]} : DW'(ref_q[i]);
          RG_CAP:   rd_mux = DW'(cap_q[i]);
          RG_EVT:   rd_mux = DW'({ev_cap[i], ev_ref[i]});
          default:  rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end

  for (genvar g = 0; g < 2; g++) begin : g_chk
    // R4: a match always leaves the reference flag set
    a_r4_match_flags: assert property (@(posedge clk) disable iff (rst)
      (match[g] && !clr[g]) |=> ev_ref[g]);
    // R7: the reference flag stays until a one is written to it
    a_r7_ref_sticky: assert property (@(posedge clk) disable iff (rst)
      (ev_ref[g] && !clr[g] && !(w1c[g] && bus_wdata[EV_REF])) |=> ev_ref[g]);
    // R8: irq rises only from a pending flag
    a_r8_irq_source: assert property (@(posedge clk) disable iff (rst)
      $rose(irq[g]) |-> $past(ev_ref[g] || ev_cap[g]));
    // R6: a capture stores the count seen at the edge
    a_r6_cap_value: assert property (@(posedge clk) disable iff (rst)
      fire[g] |=> cap_q[g] == $past(cnt_v[g]));
  end
endmodule

// File: tb/dual_timer_pair_bench.sv
module dual_timer_pair_bench;
  localparam logic [4:0] GC = 5'd0;
  localparam logic [4:0] A_MODE = 5'd8,  A_CNT = 5'd9,  A_REF = 5'd10, A_CAP = 5'd11, A_EVT = 5'd12;
  localparam logic [4:0] B_MODE = 5'd16, B_CNT = 5'd17, B_REF = 5'd18, B_EVT = 5'd20;

  typedef struct {
    logic [31:0] exp;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  cap_in = '0;
  logic [1:0]  irq;
  logic        rd_seen = 1'b0;
  logic        done = 1'b0;
  int          vectors = 0;
  int          miscompares = 0;
  item_t       sb_q[$];

  always #4 clk = ~clk;

  dual_timer_pair u_dual_timer_pair (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in), .irq(irq)
  );

  // monitor: a read issued at an edge is compared at the next falling edge
  always @(posedge clk) rd_seen <= bus_re;
  always @(negedge clk) begin
    if (rd_seen && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      vectors++;
      if (bus_rdata !== it.exp) begin
        miscompares++;
        $display("FAIL %s: read got %h expected %h", it.req, bus_rdata, it.exp);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string req);
    item_t it;
    it.exp = e; it.req = req;
    sb_q.push_back(it);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic chk(input logic [31:0] got, input logic [31:0] e, input string req);
    vectors++;
    if (got !== e) begin
      miscompares++;
      $display("FAIL %s: port got %h expected %h", req, got, e);
    end
  endtask

  // run for exactly k active edges, then stop with the given control value
  task automatic run_for(input logic [31:0] on, input logic [31:0] off, input int k);
    wr(GC, on);
    if (k > 1) idle(k - 1);
    wr(GC, off);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(1);
    // R1 reset values
    chk(32'(irq), 32'd0, "R1 irq");
    rd(GC, 32'h0, "R1 control");
    rd(A_REF, 32'hFFFF, "R1 ref A");
    rd(B_CNT, 32'h0, "R1 count B");
    rd(A_MODE, 32'h0, "R1 mode A");
    rd(A_EVT, 32'h0, "R1 event A");
    // R3 held timer ignores count writes
    wr(B_CNT, 32'h5);
    rd(B_CNT, 32'h0, "R3 held count");
    // R2 divide by 1
    wr(GC, 32'h2);
    run_for(32'h3, 32'h2, 10);
    rd(A_CNT, 32'd10, "R2 div1");
    rd(A_EVT, 32'h0, "R4 no match");
    // R2 divide by 3
    wr(A_CNT, 32'h0);
    wr(A_MODE, 32'h002);
    run_for(32'h3, 32'h2, 12);
    rd(A_CNT, 32'd4, "R2 div3");
    // R2 slow source
    wr(A_CNT, 32'h0);
    wr(A_MODE, 32'h100);
    run_for(32'h3, 32'h2, 48);
    rd(A_CNT, 32'd3, "R2 slow");
    // R4 free-run match with interrupt enable
    wr(A_CNT, 32'h0);
    wr(A_MODE, 32'h400);
    wr(A_REF, 32'h5);
    run_for(32'h3, 32'h2, 7);
    rd(A_CNT, 32'd7, "R4 free run");
    rd(A_EVT, 32'h1, "R4 flag");
    chk(32'(irq), 32'h1, "R8 ref irq");
    // R7 write-one-to-clear
    wr(A_EVT, 32'h0);
    rd(A_EVT, 32'h1, "R7 zero write");
    wr(A_EVT, 32'h1);
    rd(A_EVT, 32'h0, "R7 one write");
    idle(2);
    chk(32'(irq), 32'h0, "R8 cleared");
    // R5 restart
    wr(A_CNT, 32'h0);
    wr(A_MODE, 32'h200);
    run_for(32'h3, 32'h2, 12);
    rd(A_CNT, 32'd2, "R5 restart");
    rd(A_EVT, 32'h1, "R5 flag");
    chk(32'(irq), 32'h0, "R8 irq masked");
    wr(A_EVT, 32'h3);
    // R4 wrap and R11 no carry while separate
    wr(A_MODE, 32'h0);
    wr(A_REF, 32'hFFFF);
    wr(GC, 32'h0A);
    wr(B_CNT, 32'h7);
    wr(A_CNT, 32'hFFFE);
    run_for(32'h0B, 32'h0A, 3);
    rd(A_CNT, 32'h1, "R4 wrap");
    rd(B_CNT, 32'h7, "R11 no carry");
    rd(A_EVT, 32'h1, "R4 wrap flag");
    wr(A_EVT, 32'h3);
    // R6 capture enabled on a stopped timer
    wr(A_CNT, 32'h1234);
    wr(A_MODE, 32'h800);
    cap_in = 2'b01;
    idle(5);
    rd(A_CAP, 32'h1234, "R6 capture");
    rd(A_EVT, 32'h2, "R6 flag");
    chk(32'(irq), 32'h1, "R8 cap irq");
    wr(A_EVT, 32'h3);
    idle(2);
    chk(32'(irq), 32'h0, "R8 cap cleared");
    cap_in = 2'b00;
    idle(3);
    // R6 capture disabled
    wr(A_MODE, 32'h0);
    wr(A_CNT, 32'h4321);
    cap_in = 2'b01;
    idle(5);
    rd(A_CAP, 32'h1234, "R6 disabled");
    rd(A_EVT, 32'h0, "R6 no flag");
    cap_in = 2'b00;
    // R10 joined access
    wr(GC, 32'h1A);
    wr(B_CNT, 32'h0000FFFE);
    wr(B_REF, 32'h00010003);
    rd(B_CNT, 32'h0000FFFE, "R10 joined count");
    rd(A_CNT, 32'h0000FFFE, "R10 low half");
    rd(B_REF, 32'h00010003, "R10 joined ref");
    rd(A_REF, 32'h3, "R10 low ref");
    // R9 joined counting with carry and restart
    wr(A_MODE, 32'h200);
    run_for(32'h1F, 32'h1A, 4);
    rd(B_CNT, 32'h00010002, "R9 carry");
    rd(A_EVT, 32'h0, "R9 no match yet");
    run_for(32'h1F, 32'h1A, 1);
    rd(B_CNT, 32'h0, "R9 restart");
    rd(A_EVT, 32'h1, "R9 flag");
    rd(B_EVT, 32'h0, "R9 upper flag");
    rd(B_MODE, 32'h0, "R12 read hold");
    idle(3);
    chk(bus_rdata, 32'h0, "R12 rdata held");
    finish_up();
  end
endmodule